// File: doc/BRIEF.md
# Adaptive Prefetch Degree Controller

This block sets how many blocks ahead a sequential prefetcher runs. It watches two single-cycle event pulses: one for each prefetch sent to memory and one for each cache hit on a block that a prefetch brought in. Over a fixed sampling window it counts both. When the window closes, it checks the useful-to-issued ratio against an upper and a lower threshold. It then raises the degree by one, lowers it by one, or leaves it alone.

The degree it outputs goes straight to the address generator. A degree of zero means no prefetches are issued. No ratio can be measured while prefetching is off, so after a fixed number of silent windows the controller sets the degree back to one. The ratio test uses no divider: the hit count, shifted left by the number of fractional threshold bits, is compared with the threshold multiplied by the issue count.

Top module: `adaptive_degree_ctrl`

## Requirements
- R1: After reset the degree output is 1 and both event counts are empty.
- R2: The degree changes only at window boundaries, which come every INTERVAL_LEN cycles; the first boundary closes the INTERVAL_LEN cycles that follow reset release. Events in every cycle of a window, the last one included, count toward that window's decision.
- R3: The thresholds are unsigned fixed-point values in units of 2^-FRAC_W (FRAC_W=4 gives 12 = 0.75). At a boundary with degree > 0, if hits×2^FRAC_W > hiThresh×issues, the degree rises by one, stopping at DEG_MAX.
- R4: At a boundary with degree > 0, if hits×2^FRAC_W < loThresh×issues and the rise condition is false, the degree falls by one. Reaching 0 stops prefetching.
- R5: If the scaled hit count equals either threshold product, or lies between the two products, the degree stays the same.
- R6: A window with no issued prefetches leaves a non-zero degree unchanged.
- R7: While the degree is 0, events are ignored. After IDLE_LIMIT consecutive windows at degree 0, the degree returns to 1 at the boundary that closes the last of those windows.
- R8: Both counts are cleared at every boundary, so each decision uses only the events of its own window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issueEvt | input | 1 | Pulse: one prefetch issued this cycle |
| hitEvt | input | 1 | Pulse: one hit on a prefetched block this cycle |
| hiThresh | input | FRAC_W+1 | Upper efficiency threshold, units of 2^-FRAC_W |
| loThresh | input | FRAC_W+1 | Lower efficiency threshold, units of 2^-FRAC_W |
| degree | output | $clog2(DEG_MAX+1) | Current prefetch degree; 0 disables prefetching |

## Verification
The hardest state to reach from the ports is the idle re-enable. It needs the degree driven to zero and then held there for several whole windows, with event pulses still arriving and being ignored. The stimulus runs one low-efficiency window from reset to reach zero. It then keeps driving high-efficiency windows and checks that the degree stays at zero until exactly the IDLE_LIMIT-th boundary. A second hard case is counter clearing. It uses a high window followed by a weak one: the weak window lowers the degree only if the first window's counts were discarded.

// File: rtl/adc_pkg.sv
package adc_pkg;
  typedef struct packed {
    logic closeWin;  // last cycle of the sampling window
    logic countEn;   // degree non-zero: events are counted
  } adcStrobe_t;
endpackage

// File: rtl/adc_datapath.sv
module adc_datapath
  import adc_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  adcStrobe_t        strb,
  input  logic              issueEvt,
  input  logic              hitEvt,
  input  logic [FRAC_W:0]   hiThresh,
  input  logic [FRAC_W:0]   loThresh,
  output logic              aboveHi,
  output logic              belowLo,
  output logic              noIssue
);
  localparam int PROD_W = CNT_W + FRAC_W + 1;

  logic [CNT_W-1:0]  issueCnt, hitCnt, issueSum, hitSum;
  logic [PROD_W-1:0] hitScaled, hiProd, loProd;

  // running sums include the event of the current cycle
  always_comb begin
    issueSum  = issueCnt + CNT_W'(strb.countEn & issueEvt);
    hitSum    = hitCnt + CNT_W'(strb.countEn & hitEvt);
    hitScaled = PROD_W'(hitSum) << FRAC_W;
    hiProd    = PROD_W'(hiThresh) * PROD_W'(issueSum);
    loProd    = PROD_W'(loThresh) * PROD_W'(issueSum);
    aboveHi   = hitScaled > hiProd;
    belowLo   = hitScaled < loProd;
    noIssue   = (issueSum == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strb.closeWin) begin
      issueCnt <= '0;
      hitCnt   <= '0;
    end else begin
      issueCnt <= issueSum;
      hitCnt   <= hitSum;
    end
  end

  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.closeWin |=> (issueCnt == '0 && hitCnt == '0));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.countEn && !strb.closeWin) |=> ($stable(issueCnt) && $stable(hitCnt)));
endmodule

// File: rtl/adc_control.sv
module adc_control
  import adc_pkg::*;
#(
  parameter int INTERVAL_LEN = 32,
  parameter int DEG_MAX      = 4,
  parameter int IDLE_LIMIT   = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            aboveHi,
  input  logic                            belowLo,
  input  logic                            noIssue,
  output adcStrobe_t                      strb,
  output logic [$clog2(DEG_MAX+1)-1:0]    degreeQ
);
  localparam int DEG_W  = $clog2(DEG_MAX + 1);
  localparam int TMR_W  = (INTERVAL_LEN > 1) ? $clog2(INTERVAL_LEN) : 1;
  localparam int IDLE_W = $clog2(IDLE_LIMIT + 1);

  logic [TMR_W-1:0]  winTmr;
  logic [IDLE_W-1:0] idleCnt;
  logic              tick, degZero;

  assign tick          = (winTmr == TMR_W'(INTERVAL_LEN - 1));
  assign degZero       = (degreeQ == '0);
  assign strb.closeWin = tick;
  assign strb.countEn  = !degZero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      winTmr  <= '0;
      idleCnt <= '0;
      degreeQ <= DEG_W'(1);
    end else begin
      winTmr <= tick ? '0 : winTmr + TMR_W'(1);
      if (tick) begin
        if (degZero) begin
          if (idleCnt == IDLE_W'(IDLE_LIMIT - 1)) begin
            degreeQ <= DEG_W'(1);
            idleCnt <= '0;
          end else begin
            idleCnt <= idleCnt + IDLE_W'(1);
          end
        end else begin
          idleCnt <= '0;
          if (!noIssue) begin
            if (aboveHi) begin
              if (degreeQ != DEG_W'(DEG_MAX)) degreeQ <= degreeQ + DEG_W'(1);
            end else if (belowLo) begin
              degreeQ <= degreeQ - DEG_W'(1);
            end
          end
        end
      end
    end
  end

  // R2
  deg_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(degreeQ));
  // R3
  deg_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    degreeQ <= DEG_W'(DEG_MAX));
  // R6
  no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && noIssue && !degZero) |=> $stable(degreeQ));
  // R7
  idle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    degZero |=> (degreeQ <= DEG_W'(1)));
endmodule

// File: rtl/adaptive_degree_ctrl.sv
module adaptive_degree_ctrl
  import adc_pkg::*;
#(
  parameter int INTERVAL_LEN = 32,
  parameter int DEG_MAX      = 4,
  parameter int FRAC_W       = 4,
  parameter int IDLE_LIMIT   = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          issueEvt,
  input  logic                          hitEvt,
  input  logic [FRAC_W:0]               hiThresh,
  input  logic [FRAC_W:0]               loThresh,
  output logic [$clog2(DEG_MAX+1)-1:0]  degree
);
  localparam int CNT_W = $clog2(INTERVAL_LEN + 1);

  adcStrobe_t strb;
  logic       aboveHi, belowLo, noIssue;

  adc_control #(
    .INTERVAL_LEN(INTERVAL_LEN), .DEG_MAX(DEG_MAX), .IDLE_LIMIT(IDLE_LIMIT)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .aboveHi(aboveHi), .belowLo(belowLo),
    .noIssue(noIssue), .strb(strb), .degreeQ(degree)
  );

  adc_datapath #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .issueEvt(issueEvt),
    .hitEvt(hitEvt), .hiThresh(hiThresh), .loThresh(loThresh),
    .aboveHi(aboveHi), .belowLo(belowLo), .noIssue(noIssue)
  );
endmodule

// File: tb/test_adaptive_degree_ctrl.sv
`timescale 1ns/1ps
module test_adaptive_degree_ctrl;
  localparam int LEN = 32;
  localparam int DMAX = 4;
  localparam int FW = 4;
  localparam int IDLE = 3;

  logic clk = 0, rst_n = 0, issueEvt = 0, hitEvt = 0;
  logic [FW:0] hiThresh = 5'd12, loThresh = 5'd4;
  logic [2:0] degree;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  adaptive_degree_ctrl #(.INTERVAL_LEN(LEN), .DEG_MAX(DMAX), .FRAC_W(FW),
    .IDLE_LIMIT(IDLE)) i_adaptive_degree_ctrl (
    .clk(clk), .rst_n(rst_n), .issueEvt(issueEvt), .hitEvt(hitEvt),
    .hiThresh(hiThresh), .loThresh(loThresh), .degree(degree));

  task automatic checkDeg(string req, int expVal);
    checks++;
    if (int'(degree) != expVal) begin
      errors++;
      $display("FAIL %s: degree actual=%0d expected=%0d", req, degree, expVal);
    end
  endtask

  task automatic doReset();
    rst_n = 0; issueEvt = 0; hitEvt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  // runs one full window; lastOnly puts the events in the final cycles
  task automatic runWin(int nIss, int nHit, bit lastOnly = 0);
    for (int i = 0; i < LEN; i++) begin
      int pos = lastOnly ? (LEN - 1 - i) : i;
      issueEvt = (pos < nIss);
      hitEvt   = (pos < nHit);
      @(negedge clk);
    end
    issueEvt = 0; hitEvt = 0;
  endtask

  task automatic tResetState();
    doReset();
    checkDeg("R1 reset", 1);
  endtask

  task automatic tRiseSaturate();
    doReset();
    for (int k = 0; k < LEN / 2; k++) begin
      issueEvt = 1; hitEvt = 1; @(negedge clk);
    end
    issueEvt = 0; hitEvt = 0;
    checkDeg("R2 mid-window hold", 1);
    repeat (LEN / 2) @(negedge clk);
    checkDeg("R3 rise to 2", 2);
    runWin(16, 16); checkDeg("R3 rise to 3", 3);
    runWin(16, 16); checkDeg("R3 rise to 4", 4);
    runWin(16, 16); checkDeg("R3 saturate at max", 4);
  endtask

  task automatic tFallAndIdle();
    doReset();
    runWin(16, 0); checkDeg("R4 fall to 0", 0);
    runWin(16, 16); checkDeg("R7 ignored idle 1", 0);
    runWin(16, 16); checkDeg("R7 ignored idle 2", 0);
    runWin(16, 16); checkDeg("R7 re-enable", 1);
    runWin(16, 16); checkDeg("R7 counts again", 2);
  endtask

  task automatic tHysteresis();
    doReset();
    runWin(16, 8);  checkDeg("R5 between thresholds", 1);
    runWin(16, 12); checkDeg("R5 equal upper", 1);
    runWin(16, 4);  checkDeg("R5 equal lower", 1);
    runWin(16, 13); checkDeg("R3 just above upper", 2);
    runWin(16, 3);  checkDeg("R4 just below lower", 1);
  endtask

  task automatic tNoIssue();
    doReset();
    runWin(0, 5); checkDeg("R6 no issues", 1);
    runWin(0, 0); checkDeg("R6 silent window", 1);
  endtask

  task automatic tClearAndEdge();
    doReset();
    runWin(16, 16); checkDeg("R8 first window", 2);
    runWin(16, 2);  checkDeg("R8 counts cleared", 1);
    runWin(1, 1, 1); checkDeg("R2 last-cycle event counted", 2);
  endtask

  initial begin
    tResetState();
    tRiseSaturate();
    tFallAndIdle();
    tHysteresis();
    tNoIssue();
    tClearAndEdge();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule